// File: doc/BRIEF.md
# 64-bit Comparator Timer

This block is a memory-mapped timer built around a free-running 64-bit up-counter that software reaches as two 32-bit words. A 64-bit compare value sits beside it. When comparison is enabled and the counter has reached or passed that value, the block latches an event flag and can drive a level interrupt. An optional reload mode adds a programmed 32-bit step to the compare value after every event, which turns one-shot alarms into a periodic tick.

Software talks to the block over a plain 32-bit word bus: byte address, write strobe, write data, and a read data path that is combinational from the address. The counter runs at the input clock rate with no prescaling. Its two halves may be loaded only while counting is stopped. A consistent 64-bit sample is taken by reading the high word, then the low word, then the high word again, and retrying if the two high values differ.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: While control bit 0 is set the counter adds one on every clock; while it is clear the counter holds. Changing control bits 1 to 3 does not pause counting.
- R3: Writes to offset 0x00 (low word) and 0x04 (high word) load the counter only while control bit 0 is clear; while counting they are ignored.
- R4: With control bit 1 set, the event flag (status bit 0 at offset 0x0C) sets when the unsigned 64-bit counter is greater than or equal to the compare value (0x10 low, 0x14 high), including when only the high word is larger, and stays clear when the counter is below it.
- R5: An event is raised only when the match condition turns true (or after a reload). Once the flag is cleared, a condition that simply keeps holding does not set it again.
- R6: While control bit 1 is clear the flag never sets, so a compare value that is only half rewritten cannot raise an event.
- R7: With control bit 3 set, each event adds the 32-bit step at offset 0x18 (zero-extended) to the compare value; if the counter is still at or past the new value, another event follows on the next cycle until the compare value moves ahead.
- R8: Writing 1 to status bit 0 clears the flag and writing 0 leaves it alone; if an event and a clearing write land on the same clock, the flag stays set.
- R9: `irq` is high exactly when the flag is set and control bits 1 and 2 are both set.
- R10: Control (0x08) reads back bits 3:0 with the rest zero; status reads back the flag in bit 0 with the rest zero; the step reads back as written; any offset above 0x18 reads zero.
- R11: A high-low-high read sequence that straddles a low-word rollover yields, after one retry, a 64-bit value equal to the counter's true value at the low-word read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data of the addressed register, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps the counter across a window of values around a compare value whose low word sits at the sign boundary, with the high word one below, equal and one above; a comparator that only checked equality, or compared the halves separately or as signed numbers, gets cases in this window wrong. It loads a compare value far behind a stopped counter under reload mode and expects the compare value to step forward until it passes the counter. A design that re-armed only on the match turning true would stop after one step, and one that ignored the bus on a reload cycle would drift. It times a clearing write against an event on the same edge, rewrites the compare words with comparison off, and reads the counter in split form across a low-word carry. A wrong flag priority would lose that event, a missing enable gate would flag the half-written value, and a missing carry into the high word would break the split read.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
// ct_pkg: shared register selection codes, control layout and word-index
// bases for the comparator timer. Assumes a 32-bit word-addressed map.
package ct_pkg;

    // Number of decoded register words; everything above reads as zero.
    localparam int NUM_REGS = 7;
    // Word index of the first counter word and the first compare word.
    localparam int CNT_BASE = 0;
    localparam int CMP_BASE = 4;
    // The 64-bit counter and compare value span this many bus words.
    localparam int NUM_WORDS = 2;

    typedef enum logic [2:0] {
        RG_CNT_LO  = 3'd0,
        RG_CNT_HI  = 3'd1,
        RG_CTRL    = 3'd2,
        RG_STAT    = 3'd3,
        RG_CMP_LO  = 3'd4,
        RG_CMP_HI  = 3'd5,
        RG_STEP    = 3'd6,
        RG_NONE    = 3'd7
    } reg_sel_e;

    // Packed so that run is bit 0 and auto_inc is bit 3 of the control word.
    typedef struct packed {
        logic auto_inc;
        logic irq_en;
        logic cmp_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/ct_decode.sv
`timescale 1ns/1ps
// ct_decode: turns a byte address into a register select code.
// Assumes word-aligned access; the two lowest address bits are ignored.
// Word indices at or beyond NUM_REGS map to RG_NONE.
module ct_decode #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output ct_pkg::reg_sel_e    sel
);
    import ct_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;

    assign idx = addr[ADDR_W-1:2];

    // Select the addressed register, or none for reserved offsets.
    always_comb begin
        if (int'(idx) < NUM_REGS) begin
            sel = reg_sel_e'(idx[2:0]);
        end else begin
            sel = RG_NONE;
        end
    end

endmodule

// File: rtl/ct_counter.sv
`timescale 1ns/1ps
// ct_counter: free-running up-counter of NUM_WORDS bus words.
// Counts by one per clock while run is high. Word loads are accepted only
// while run is low; the caller supplies one write strobe per word.
module ct_counter #(
    parameter int WORD_W = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    run,
    input  logic [ct_pkg::NUM_WORDS-1:0]            wr_word,
    input  logic [WORD_W-1:0]                       wdata,
    output logic [ct_pkg::NUM_WORDS*WORD_W-1:0]     cnt
);
    import ct_pkg::*;

    localparam int CNT_W = NUM_WORDS * WORD_W;

    // Count while running, otherwise load any strobed words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end else begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (wr_word[i]) begin
                    cnt[i*WORD_W +: WORD_W] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/ct_compare.sv
`timescale 1ns/1ps
// ct_compare: greater-or-equal comparator with event flag and step reload.
// An event fires when the enabled match condition is true and was not
// already seen; a reload clears the seen state so a still-passed value fires
// again. Bus writes to the compare words take priority over a reload.
// On the flag, a new event wins over a clearing write on the same clock.
module ct_compare #(
    parameter int WORD_W = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [ct_pkg::NUM_WORDS*WORD_W-1:0]     cnt,
    input  logic                                    cmp_en,
    input  logic                                    auto_en,
    input  logic [ct_pkg::NUM_WORDS-1:0]            wr_word,
    input  logic                                    wr_step,
    input  logic [WORD_W-1:0]                       wdata,
    input  logic                                    clr_flag,
    output logic                                    flag,
    output logic [ct_pkg::NUM_WORDS*WORD_W-1:0]     cmp,
    output logic [WORD_W-1:0]                       step
);
    import ct_pkg::*;

    localparam int CNT_W = NUM_WORDS * WORD_W;

    logic match;
    logic seen_q;
    logic fire;
    logic reload;

    assign match  = cmp_en && (cnt >= cmp);
    assign fire   = match && !seen_q;
    assign reload = fire && auto_en && (wr_word == '0);

    // Remember that the current match has been reported, unless reloaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= match && !reload;
        end
    end

    // Hold the compare value: bus words first, then step reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (wr_word != '0) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (wr_word[i]) begin
                    cmp[i*WORD_W +: WORD_W] <= wdata;
                end
            end
        end else if (reload) begin
            cmp <= cmp + CNT_W'(step);
        end
    end

    // Hold the reload step written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (wr_step) begin
            step <= wdata;
        end
    end

    // Event flag: set on a fresh event, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (fire) begin
            flag <= 1'b1;
        end else if (clr_flag) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
// cmp_timer: memory-mapped 64-bit timer with greater-or-equal comparator,
// step reload and level interrupt. Read data is combinational from the
// address; writes take effect on the rising clock edge. The counter runs
// at the clock rate with no prescaler.
module cmp_timer #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                irq
);
    import ct_pkg::*;

    localparam int CNT_W  = NUM_WORDS * WORD_W;
    localparam int CTRL_W = $bits(ctrl_t);

    reg_sel_e               sel;
    ctrl_t                  ctrl_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       cmp_q;
    logic [WORD_W-1:0]      step_q;
    logic                   flag_q;
    logic [NUM_WORDS-1:0]   wr_cnt_word;
    logic [NUM_WORDS-1:0]   wr_cmp_word;
    logic                   wr_step;
    logic                   clr_flag;

    ct_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .sel    (sel)
    );

    // One write strobe per word of the counter and of the compare value.
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word_strobe
        assign wr_cnt_word[g] = bus_we && (sel == reg_sel_e'(3'(CNT_BASE + g)));
        assign wr_cmp_word[g] = bus_we && (sel == reg_sel_e'(3'(CMP_BASE + g)));
    end

    assign wr_step  = bus_we && (sel == RG_STEP);
    assign clr_flag = bus_we && (sel == RG_STAT) && bus_wdata[0];

    // Control register: keep the low control bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_we && (sel == RG_CTRL)) begin
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    ct_counter #(.WORD_W(WORD_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .wr_word (wr_cnt_word),
        .wdata   (bus_wdata),
        .cnt     (cnt_q)
    );

    ct_compare #(.WORD_W(WORD_W)) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt_q),
        .cmp_en   (ctrl_q.cmp_en),
        .auto_en  (ctrl_q.auto_inc),
        .wr_word  (wr_cmp_word),
        .wr_step  (wr_step),
        .wdata    (bus_wdata),
        .clr_flag (clr_flag),
        .flag     (flag_q),
        .cmp      (cmp_q),
        .step     (step_q)
    );

    // Read mux: addressed register, zero for reserved offsets.
    always_comb begin
        case (sel)
            RG_CNT_LO: bus_rdata = cnt_q[WORD_W-1:0];
            RG_CNT_HI: bus_rdata = cnt_q[CNT_W-1:WORD_W];
            RG_CTRL:   bus_rdata = {(WORD_W-CTRL_W)'(0), ctrl_q};
            RG_STAT:   bus_rdata = {(WORD_W-1)'(0), flag_q};
            RG_CMP_LO: bus_rdata = cmp_q[WORD_W-1:0];
            RG_CMP_HI: bus_rdata = cmp_q[CNT_W-1:WORD_W];
            RG_STEP:   bus_rdata = step_q;
            default:   bus_rdata = '0;
        endcase
    end

    // Level interrupt gated by both enables.
    assign irq = flag_q && ctrl_q.irq_en && ctrl_q.cmp_en;

endmodule

// File: rtl/ct_checker.sv
`timescale 1ns/1ps
// ct_checker: temporal properties of cmp_timer, bound to every instance.
// Observes the bus, the counter, the compare value, the flag and control.
module ct_checker #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [ADDR_W-1:0]                       bus_addr,
    input  logic                                    bus_we,
    input  logic [WORD_W-1:0]                       bus_wdata,
    input  logic [WORD_W-1:0]                       bus_rdata,
    input  logic [ct_pkg::NUM_WORDS*WORD_W-1:0]     cnt,
    input  logic [ct_pkg::NUM_WORDS*WORD_W-1:0]     cmp,
    input  logic                                    flag,
    input  ct_pkg::ctrl_t                           ctrl
);
    logic cnt_write;
    logic stat_clear;

    assign cnt_write  = bus_we && (bus_addr[ADDR_W-1:3] == '0);
    assign stat_clear = bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3)) && bus_wdata[0];

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.run |=> (cnt == $past(cnt) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !cnt_write) |=> $stable(cnt));

    // R6
    no_event_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.cmp_en |=> !$rose(flag));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && stat_clear && !(ctrl.cmp_en && (cnt >= cmp))) |=> !flag);

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr[ADDR_W-1:2]) >= ct_pkg::NUM_REGS) |-> (bus_rdata == '0));

endmodule

bind cmp_timer ct_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt_q),
    .cmp       (cmp_q),
    .flag      (flag_q),
    .ctrl      (ctrl_q)
);

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
// cmp_timer_bench: directed sweeps over the timer with expected values
// computed from the register semantics. One bus operation per clock,
// each starting at a falling edge.
module cmp_timer_bench;

    localparam logic [7:0] A_CLO  = 8'h00;
    localparam logic [7:0] A_CHI  = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_STAT = 8'h0C;
    localparam logic [7:0] A_MLO  = 8'h10;
    localparam logic [7:0] A_MHI  = 8'h14;
    localparam logic [7:0] A_STEP = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int   n_checks = 0;
    int   n_err = 0;
    int   ticks = 0;
    int   rd_tick = 0;
    logic irq_s = 1'b0;
    logic done = 1'b0;

    cmp_timer u_cmp_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) ticks++;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        addr = a; we = 1'b1; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a; we = 1'b0;
        #1;
        v = rdata; irq_s = irq; rd_tick = ticks;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stop everything, clear the flag, and load counter and compare value.
    task automatic setup(input logic [63:0] c, input logic [63:0] m);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h1);
        wr(A_CLO, c[31:0]);
        wr(A_CHI, c[63:32]);
        wr(A_MLO, m[31:0]);
        wr(A_MHI, m[63:32]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, hi1, hi2, lo;
        logic [63:0] c, m, start;
        int t0, k, tries, lo_tick;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 7; i++) begin
            rd(8'(i * 4), d);
            check("R1 reset reg", d, 0);
        end
        check("R1 irq low", irq_s, 0);

        // R10: read-back rules
        wr(A_CTRL, 32'hFFFF_FFF0);
        rd(A_CTRL, d);
        check("R10 ctrl upper bits", d, 0);
        wr(A_STEP, 32'hABCD_1234);
        rd(A_STEP, d);
        check("R10 step readback", d, 32'hABCD_1234);
        rd(8'h1C, d);
        check("R10 reserved 0x1C", d, 0);
        rd(8'h40, d);
        check("R10 reserved 0x40", d, 0);
        rd(A_STAT, d);
        check("R10 status zero", d, 0);

        // R2 / R3: counting, hold and load gating
        setup(64'h100, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_CLO, d);
        check("R3 load while stopped", d, 32'h100);
        wr(A_CTRL, 32'h1);
        t0 = ticks;
        idle(3);
        rd(A_CLO, d);
        check("R2 counting", d, 32'(32'h100 + (rd_tick - t0)));
        wr(A_CTRL, 32'h7);
        wr(A_CTRL, 32'h1);
        rd(A_CLO, d);
        check("R2 counting after enable changes", d, 32'(32'h100 + (rd_tick - t0)));
        wr(A_CLO, 32'hDEAD);
        rd(A_CLO, d);
        check("R3 load ignored while counting", d, 32'(32'h100 + (rd_tick - t0)));
        wr(A_CTRL, 32'h0);
        k = 32'h100 + (ticks - t0);
        idle(3);
        rd(A_CLO, d);
        check("R2 hold when stopped", d, 32'(k));
        wr(A_CLO, 32'h55);
        wr(A_CHI, 32'h66);
        rd(A_CLO, d);
        check("R3 low word load", d, 32'h55);
        rd(A_CHI, d);
        check("R3 high word load", d, 32'h66);

        // R4 / R6 / R9: greater-or-equal sweep around a compare value
        m = 64'h0000_0010_8000_0000;
        for (int dh = -1; dh <= 1; dh++) begin
            for (int dl = -2; dl <= 2; dl++) begin
                c = m;
                if (dh < 0) c = c - 64'h1_0000_0000;
                if (dh > 0) c = c + 64'h1_0000_0000;
                if (dl < 0) c = c - 64'(-dl);
                else        c = c + 64'(dl);
                wr(A_CTRL, 32'h0);
                wr(A_STAT, 32'h1);
                wr(A_CLO, c[31:0]);
                wr(A_CHI, c[63:32]);
                wr(A_MHI, 32'h0);
                wr(A_MLO, m[31:0]);
                rd(A_STAT, d);
                check("R6 half-written compare", d, 0);
                wr(A_MHI, m[63:32]);
                wr(A_CTRL, 32'h6);
                idle(1);
                rd(A_STAT, d);
                check("R4 flag vs compare", d, {31'h0, (c >= m)});
                check("R9 irq with both enables", irq_s, (c >= m));
            end
        end

        // R8 / R5 / R9: set wins over clear, write of zero, no re-trigger
        setup(64'd9, 64'd3);
        wr(A_CTRL, 32'h2);
        wr(A_STAT, 32'h1);
        rd(A_STAT, d);
        check("R8 event beats clear", d, 1);
        check("R9 irq gated by irq enable", irq_s, 0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d);
        check("R8 write of zero keeps flag", d, 1);
        wr(A_STAT, 32'h1);
        idle(2);
        rd(A_STAT, d);
        check("R5 held match does not re-trigger", d, 0);

        // R7: periodic events every step
        setup(64'd0, 64'd5);
        wr(A_STEP, 32'd4);
        wr(A_CTRL, 32'hF);
        k = 0;
        for (int cyc = 0; cyc < 60 && k < 4; cyc++) begin
            rd(A_CLO, d);
            if (irq_s) begin
                check("R7 periodic event time", d, 32'(6 + 4 * k));
                k++;
                wr(A_STAT, 32'h1);
            end
        end
        check("R7 periodic event count", 64'(k), 4);

        // R7 / R5: compare value far behind a stopped counter catches up
        setup(64'd100, 64'd0);
        wr(A_STEP, 32'd10);
        wr(A_CTRL, 32'hA);
        idle(20);
        rd(A_MLO, d);
        check("R7 catch-up compare low", d, 110);
        rd(A_MHI, d);
        check("R7 catch-up compare high", d, 0);
        wr(A_STAT, 32'h1);
        idle(2);
        rd(A_STAT, d);
        check("R5 no event once caught up", d, 0);

        // R11: split read across a low-word carry
        start = 64'h0000_0005_FFFF_FFFE;
        setup(start, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(A_CTRL, 32'h1);
        t0 = ticks;
        tries = 0;
        lo_tick = 0;
        lo = '0;
        rd(A_CHI, hi2);
        do begin
            hi1 = hi2;
            rd(A_CLO, lo);
            lo_tick = rd_tick;
            rd(A_CHI, hi2);
            tries++;
        end while (hi1 != hi2 && tries < 5);
        check("R11 retry taken", 64'(tries), 2);
        check("R11 assembled value", {hi2, lo}, start + 64'(lo_tick - t0));
        wr(A_CTRL, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule